// File: doc/BRIEF.md
# PCI Address Phase Rule Monitor

A passive observer for a 64-bit PCI bus. It watches the start of every transaction and checks the command and address presented in the address phase against a set of bus rules. It also follows the two-clock dual address cycle (DAC), in which the first clock carries the low address and the DAC command, and the second clock carries the real command and the upper address. The monitor never drives the bus.

Each rule owns a sticky error flag that stays set until reset. A 5-bit code output names the violation for exactly one clock after the edge on which it was sampled. Memory write and invalidate starts are checked against a cacheline size that software supplies in dwords. Data-phase parity, target responses and arbitration are not observed.

Top module: `pci_addr_rule_mon`

## Requirements
- R1: An address phase is the rising edge at which `bus_start_l` is sampled low and the previous edge sampled both `bus_start_l` and `init_rdy_l` high. `bus_start_l` low at any other edge raises nothing, unless it is the DAC second clock.
- R2: A single-clock address phase whose command (the value on `cmd_be_l`) is 4'h4, 4'h5, 4'h8 or 4'h9 raises code 1.
- R3: A memory write (4'h7) or memory write and invalidate (4'hF) whose low address bits [1:0] are not 00 raises code 2.
- R4: A memory write and invalidate whose byte address is not a multiple of `line_dwords`*4 raises code 3. When `line_dwords` is zero, this check is off.
- R5: A 64-bit request (`wide_req_l` low) with a command outside the memory set {4'h6, 4'h7, 4'hC, 4'hD, 4'hE, 4'hF} raises code 4.
- R6: In a DAC (first-clock command 4'hD), a second-clock command that is reserved or 4'hD raises code 5.
- R7: In a DAC, an upper address (bits [31:0] on the second clock) equal to zero raises code 6.
- R8: In a DAC first clock with `wide_req_l` low, `addr_data[63:32]` differing from `addr_data[31:0]` raises code 7.
- R9: In a DAC, the R3, R4 and R5 checks use the second-clock command together with the low address and the 64-bit request sampled on the first clock. They are not applied on the first clock.
- R10: Bit n-1 of `rule_err` is set with code n and holds until reset. Reset clears `rule_err` and `err_code`.
- R11: `err_code` shows the lowest code among the violations sampled at an edge, for the single cycle that follows that edge. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_start_l | input | 1 | Transaction-in-progress strobe, active low |
| init_rdy_l | input | 1 | Initiator ready strobe, active low |
| addr_data | input | 64 | Multiplexed address/data lines |
| cmd_be_l | input | 4 | Command / byte-enable lines |
| wide_req_l | input | 1 | 64-bit transfer request, active low |
| line_dwords | input | LINE_W | Cacheline size in dwords (power of two, 0 = off) |
| rule_err | output | 7 | Sticky flag per rule, bit n-1 for code n |
| err_code | output | CODE_W | One-cycle violation code, 0 = none |

## Verification
The bench builds the monitor with LINE_W = 8 and CODE_W = 5. This allows cacheline sizes up to 128 dwords. The run switches between 16 dwords and zero, so the R4 check is exercised both enabled and disabled. Several cases raise two rules at once (an unaligned memory write and invalidate; a reserved second-clock command with a 64-bit request), which brings the R11 priority choice within reach. DAC cases with a mismatched or zero upper half and a swapped second-clock command cover the two-clock path.

// File: rtl/pci_addr_rule_mon.sv
module pci_addr_rule_mon #(
  parameter int LINE_W = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start_l,
  input  logic              init_rdy_l,
  input  logic [63:0]       addr_data,
  input  logic [3:0]        cmd_be_l,
  input  logic              wide_req_l,
  input  logic [LINE_W-1:0] line_dwords,
  output logic [6:0]        rule_err,
  output logic [CODE_W-1:0] err_code
);
  localparam int NRULE  = 7;
  localparam int MASK_W = LINE_W + 2;

  function automatic logic is_rsv(input logic [3:0] c);
    return (c == 4'h4) || (c == 4'h5) || (c == 4'h8) || (c == 4'h9);
  endfunction

  function automatic logic is_mem(input logic [3:0] c);
    return (c == 4'h6) || (c == 4'h7) || (c >= 4'hC);
  endfunction

  logic        idle_q, dac_q, wide_q;
  logic [31:0] lo_q;
  logic [NRULE-1:0]  viol;
  logic [CODE_W-1:0] code_d;

  wire aphase    = idle_q & ~bus_start_l;
  wire dac_first = aphase & (cmd_be_l == 4'hD);
  wire single    = aphase & ~dac_first;
  wire eval      = single | dac_q;

  wire [31:0]       eff_lo    = dac_q ? lo_q : addr_data[31:0];
  wire              eff_wide  = dac_q ? wide_q : ~wide_req_l;
  wire [MASK_W-1:0] line_mask = {line_dwords, 2'b00} - MASK_W'(1);
  wire              is_wr     = (cmd_be_l == 4'h7) || (cmd_be_l == 4'hF);

  assign viol[0] = single & is_rsv(cmd_be_l);
  assign viol[1] = eval & is_wr & (|eff_lo[1:0]);
  assign viol[2] = eval & (cmd_be_l == 4'hF) & (|line_dwords)
                 & (|(eff_lo[MASK_W-1:0] & line_mask));
  assign viol[3] = eval & eff_wide & ~is_mem(cmd_be_l);
  assign viol[4] = dac_q & (is_rsv(cmd_be_l) || cmd_be_l == 4'hD);
  assign viol[5] = dac_q & (addr_data[31:0] == 32'h0);
  assign viol[6] = dac_first & ~wide_req_l & (addr_data[63:32] != addr_data[31:0]);

  always_comb begin
    code_d = '0;
    for (int i = NRULE - 1; i >= 0; i--)
      if (viol[i]) code_d = CODE_W'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q   <= 1'b0;
      dac_q    <= 1'b0;
      wide_q   <= 1'b0;
      lo_q     <= '0;
      rule_err <= '0;
      err_code <= '0;
    end else begin
      idle_q   <= bus_start_l & init_rdy_l;
      dac_q    <= dac_first;
      rule_err <= rule_err | viol;
      err_code <= code_d;
      if (dac_first) begin
        lo_q   <= addr_data[31:0];
        wide_q <= ~wide_req_l;
      end
    end
  end

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rule_err & $past(rule_err)) == $past(rule_err)));

  // R11
  code_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != '0) |-> (err_code <= CODE_W'(NRULE)) && rule_err[err_code - CODE_W'(1)]);

  // R1
  code_only_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aphase == 1'b0 && dac_q == 1'b0) |=> (err_code == '0));

  // R2
  reserved_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single && is_rsv(cmd_be_l)) |=> (err_code == CODE_W'(1)) && rule_err[0]);

  // R7
  dac_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_q && addr_data[31:0] == 32'h0) |=> rule_err[5] && (err_code != '0));
endmodule

// File: tb/pci_addr_rule_mon_tb.sv
`timescale 1ns/1ps
module pci_addr_rule_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr = 1'b1, ir = 1'b1, wl = 1'b1;
  logic [63:0] ad = '0;
  logic [3:0]  cb = '0;
  logic [7:0]  line = 8'd16;
  logic [6:0]  flags;
  logic [4:0]  code;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_idle = 0, m_dac = 0, m_wide = 0;
  logic [31:0] m_lo = '0;
  logic [6:0]  ef = '0;
  logic [4:0]  ec = '0;

  pci_addr_rule_mon #(.LINE_W(8), .CODE_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_start_l(fr), .init_rdy_l(ir),
    .addr_data(ad), .cmd_be_l(cb), .wide_req_l(wl), .line_dwords(line),
    .rule_err(flags), .err_code(code));

  always #2 clk = ~clk;

  function automatic bit rsv(int c); return c == 4 || c == 5 || c == 8 || c == 9; endfunction
  function automatic bit mem(int c); return c == 6 || c == 7 || c >= 12; endfunction

  function automatic logic [6:0] common(int c, logic [31:0] lo, int w);
    logic [6:0] v = '0;
    if ((c == 7 || c == 15) && lo[1:0] != 2'b00) v[1] = 1'b1;
    if (c == 15 && line != 0 && (lo % (32'(line) * 4)) != 0) v[2] = 1'b1;
    if (w != 0 && !mem(c)) v[3] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag);
    tests++;
    if (code !== ec) begin
      fails++;
      $display("FAIL %s code actual=%0d expected=%0d", tag, code, ec);
    end
    tests++;
    if (flags !== ef) begin
      fails++;
      $display("FAIL %s flags actual=%b expected=%b", tag, flags, ef);
    end
  endtask

  task automatic cyc(logic f, logic i, logic [3:0] c, logic [63:0] a, logic w, string tag);
    logic [6:0] v = '0;
    @(negedge clk);
    fr = f; ir = i; cb = c; ad = a; wl = w;
    @(posedge clk);
    if (m_dac != 0) begin
      if (rsv(c) || c == 13) v[4] = 1'b1;
      if (a[31:0] == 0) v[5] = 1'b1;
      v |= common(c, m_lo, m_wide);
      m_dac = 0;
    end else if (m_idle != 0 && !f) begin
      if (c == 13) begin
        m_dac = 1; m_lo = a[31:0]; m_wide = !w;
        if (!w && a[63:32] != a[31:0]) v[6] = 1'b1;
      end else begin
        if (rsv(c)) v[0] = 1'b1;
        v |= common(c, a[31:0], !w);
      end
    end
    m_idle = (f && i) ? 1 : 0;
    ef |= v;
    ec = 0;
    for (int k = 6; k >= 0; k--) if (v[k]) ec = 5'(k + 1);
    #1 check(tag);
  endtask

  task automatic txn(logic [3:0] c, logic [63:0] a, logic w, string tag);
    cyc(1'b0, 1'b1, c, a, w, tag);
    cyc(1'b1, 1'b0, 4'h0, 64'h0, 1'b1, "R1");
    cyc(1'b1, 1'b1, 4'h0, 64'h0, 1'b1, "R1");
  endtask

  task automatic dac(logic [3:0] c2, logic [63:0] a1, logic [31:0] up, logic w, string tag);
    cyc(1'b0, 1'b1, 4'hD, a1, w, tag);
    cyc(1'b0, 1'b1, c2, {32'h0, up}, w, tag);
    cyc(1'b1, 1'b0, 4'h0, 64'h0, 1'b1, "R1");
    cyc(1'b1, 1'b1, 4'h0, 64'h0, 1'b1, "R1");
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10");
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b1, 1'b1, 4'h0, 64'h0, 1'b1, "R10");
    txn(4'h6, 64'h1000, 1'b1, "R11");
    txn(4'h4, 64'h1000, 1'b1, "R2");
    txn(4'h9, 64'h2000, 1'b1, "R2");
    txn(4'h7, 64'h1002, 1'b1, "R3");
    txn(4'hF, 64'h1001, 1'b1, "R11");
    txn(4'hF, 64'h1040, 1'b1, "R4");
    txn(4'hF, 64'h1020, 1'b1, "R4");
    line = 8'd0;
    txn(4'hF, 64'h1020, 1'b1, "R4");
    line = 8'd16;
    txn(4'h2, 64'h10, 1'b0, "R5");
    txn(4'h6, 64'h100, 1'b0, "R5");
    dac(4'hD, 64'h0000_0000_0000_1000, 32'h5, 1'b1, "R6");
    dac(4'h8, 64'h0000_0000_0000_1000, 32'h5, 1'b1, "R6");
    dac(4'h8, 64'h0000_1000_0000_1000, 32'h5, 1'b0, "R11");
    dac(4'h6, 64'h0000_0000_0000_1000, 32'h0, 1'b1, "R7");
    dac(4'h6, 64'h0000_0002_0000_1000, 32'h2, 1'b0, "R8");
    dac(4'h6, 64'h0000_1000_0000_1000, 32'h2, 1'b0, "R8");
    dac(4'h7, 64'h0000_0000_0000_1002, 32'h3, 1'b1, "R9");
    dac(4'h2, 64'h0000_1000_0000_1000, 32'h3, 1'b0, "R9");
    dac(4'hF, 64'h0000_0000_0000_1010, 32'h3, 1'b1, "R9");
    cyc(1'b0, 1'b0, 4'h0, 64'h0, 1'b1, "R1");
    cyc(1'b1, 1'b0, 4'h0, 64'h0, 1'b1, "R1");
    cyc(1'b0, 1'b1, 4'h4, 64'h0, 1'b0, "R1");
    cyc(1'b1, 1'b1, 4'h0, 64'h0, 1'b1, "R1");
    repeat (2) cyc(1'b1, 1'b1, 4'h0, 64'h0, 1'b1, "R10");
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk);
    ef = '0; ec = '0; m_idle = 0; m_dac = 0;
    #1 check("R10");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule